// File: doc/BRIEF.md
# Program Counter and Next-Address Fetch Unit

This block owns the 32-bit program counter of a one-instruction-per-cycle processor core. Each cycle it presents the word stored at the current PC from a local instruction store, and picks the address of the following instruction. The decoder supplies a jump control and a branch control. The datapath supplies the ALU zero flag. The fetched word supplies the 16-bit immediate and the 26-bit jump target.

There are three next-address cases. A sequential step adds four. A taken branch adds four plus the sign-extended immediate scaled to bytes. A jump keeps the top four bits of the current PC and places the 26-bit target, shifted to a word boundary, below them. All state changes on the falling clock edge. The instruction store is filled through a simple word-wide load port, and reads from it are combinational.

Top module: `fetch_unit`

## Requirements
- R1: When `rst` is high at a falling clock edge, the PC becomes 0x00000000. It stays there for as long as `rst` stays high, and `instr_o` then shows word 0 of the store.
- R2: With `jmp_sel` low and `br_sel` low, the next PC is the current PC plus 4.
- R3: With `jmp_sel` low, `br_sel` high and `alu_zero` high, and a non-negative `imm16`, the next PC is PC + 4 + `imm16`×4. This is a forward branch.
- R4: When `imm16` has bit 15 set, it is treated as a negative two's-complement word count, so the same branch moves the PC backwards. The result wraps modulo 2^32.
- R5: With `br_sel` high and `alu_zero` low, the branch is not taken and the next PC is PC + 4.
- R6: With `alu_zero` high and `br_sel` low, the next PC is PC + 4.
- R7: With `jmp_sel` high, the next PC is {PC[31:28], `jtarget`, 2'b00}, where PC[31:28] comes from the current PC. This holds whatever `br_sel` and `alu_zero` are.
- R8: `instr_o` is the store word at index PC[IMEM_AW+1:2]. It follows every PC change without an extra cycle, and PC bits above the index are not decoded.
- R9: The PC changes only on the falling clock edge. A rising edge leaves `pc_o` unchanged, and PC[1:0] are always 00.
- R10: When `ld_en` is high at a falling edge, `ld_data` is written to store word `ld_addr`. Writes can happen while `rst` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset of the PC |
| br_sel | input | 1 | Branch-select control from decode |
| alu_zero | input | 1 | Zero flag from the datapath ALU |
| jmp_sel | input | 1 | Jump control from decode |
| imm16 | input | 16 | Branch offset field, in words |
| jtarget | input | 26 | Jump target field, in words |
| ld_en | input | 1 | Instruction store write enable |
| ld_addr | input | IMEM_AW | Instruction store word index to write |
| ld_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current PC |

## Verification
The bench fills every word of the store with a distinct, address-derived value, so a wrong fetch index shows up as a wrong `instr_o` as well as a wrong `pc_o`. It pairs the branch control with each state of the zero flag. A design that gated on only one of the two would branch when it should step by four, or step by four when it should branch.

A negative offset that carries the PC below zero checks sign extension. A design that zero-extended the immediate would land far ahead instead of wrapping into the 0xFFFFFFxx range. A later jump from that region must keep 0xF in the top nibble, which catches a design that clears or re-uses stale upper bits. A jump issued together with a taken branch catches a wrong priority order. Checking `pc_o` just after each rising edge catches a register clocked on the wrong edge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int PC_W    = 32;
    localparam int INSTR_W = 32;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;
    localparam int WORD_SH = 2;
    localparam int HI_W    = PC_W - TGT_W - WORD_SH;
    localparam int EXT_W   = PC_W - IMM_W - WORD_SH;

    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [IMM_W-1:0]   imm_t;
    typedef logic [TGT_W-1:0]   tgt_t;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_BRANCH = 2'd1,
        NXT_JUMP   = 2'd2
    } nxt_kind_e;

    typedef struct packed {
        logic br_sel;
        logic alu_zero;
        logic jmp_sel;
    } fetch_ctl_t;

    // Jump wins over a taken branch; a branch needs both select and zero.
    function automatic nxt_kind_e pick_kind(fetch_ctl_t c);
        if (c.jmp_sel)                return NXT_JUMP;
        else if (c.br_sel && c.alu_zero) return NXT_BRANCH;
        else                          return NXT_SEQ;
    endfunction

    // Sign-extend a word offset and scale it to bytes.
    function automatic pc_t word_offset(imm_t imm);
        return {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SH{1'b0}}};
    endfunction

    // Region-relative jump: keep the top bits of the current PC.
    function automatic pc_t jump_dest(pc_t pc, tgt_t tgt);
        return {pc[PC_W-1 -: HI_W], tgt, {WORD_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
    import fetch_pkg::*;
(
    input  pc_t        pc_q,
    input  fetch_ctl_t ctl,
    input  imm_t       imm,
    input  tgt_t       tgt,
    output pc_t        pc_d
);

    localparam pc_t STEP = pc_t'(1) << WORD_SH;

    pc_t       seq_pc;
    nxt_kind_e kind;

    always_comb begin
        seq_pc = pc_q + STEP;
        kind   = pick_kind(ctl);
        unique case (kind)
            NXT_JUMP:   pc_d = jump_dest(pc_q, tgt);
            NXT_BRANCH: pc_d = seq_pc + word_offset(imm);
            default:    pc_d = seq_pc;
        endcase
    end

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter pc_t RESET_PC = '0
) (
    input  logic clk,
    input  logic rst,
    input  pc_t  pc_d,
    output pc_t  pc_q
);

    always_ff @(negedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_d;
    end

endmodule

// File: rtl/fetch_imem.sv
module fetch_imem
    import fetch_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  instr_t        wdata,
    input  logic [AW-1:0] raddr,
    output instr_t        rdata
);

    localparam int DEPTH = 1 << AW;

    instr_t store [DEPTH];

    always_ff @(negedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int IMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_sel,
    input  logic               alu_zero,
    input  logic               jmp_sel,
    input  logic [15:0]        imm16,
    input  logic [25:0]        jtarget,
    input  logic               ld_en,
    input  logic [IMEM_AW-1:0] ld_addr,
    input  logic [31:0]        ld_data,
    output logic [31:0]        pc_o,
    output logic [31:0]        instr_o
);

    localparam int IDX_LO = WORD_SH;
    localparam int IDX_HI = WORD_SH + IMEM_AW - 1;

    fetch_ctl_t ctl;
    pc_t        pc_q;
    pc_t        pc_d;

    assign ctl = '{br_sel: br_sel, alu_zero: alu_zero, jmp_sel: jmp_sel};

    fetch_next_pc u_next (
        .pc_q (pc_q),
        .ctl  (ctl),
        .imm  (imm16),
        .tgt  (jtarget),
        .pc_d (pc_d)
    );

    fetch_pc_reg #(.RESET_PC('0)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .pc_d (pc_d),
        .pc_q (pc_q)
    );

    fetch_imem #(.AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (ld_en),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pc_q[IDX_HI:IDX_LO]),
        .rdata (instr_o)
    );

    assign pc_o = pc_q;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        br_sel,
    input logic        alu_zero,
    input logic        jmp_sel,
    input logic [15:0] imm16,
    input logic [25:0] jtarget,
    input logic [31:0] pc_o
);

    // R1: reset sampled high puts the PC at zero
    assert_reset_zero_R1: assert property (@(negedge clk)
        rst |=> (pc_o == 32'h0));

    // R2, R5, R6: no jump and no taken branch means a plain step of four
    assert_seq_step_R2: assert property (@(negedge clk) disable iff (rst)
        (!jmp_sel && !(br_sel && alu_zero)) |=> (pc_o == $past(pc_o) + 32'd4));

    // R3, R4: taken branch adds the scaled signed offset after the step
    assert_branch_dest_R3: assert property (@(negedge clk) disable iff (rst)
        (!jmp_sel && br_sel && alu_zero) |=>
        (pc_o == $past(pc_o) + 32'd4 + ($past({{16{imm16[15]}}, imm16}) << 2)));

    // R7: jump keeps the old top nibble and takes the target
    assert_jump_dest_R7: assert property (@(negedge clk) disable iff (rst)
        jmp_sel |=> (pc_o == {$past(pc_o[31:28]), $past(jtarget), 2'b00}));

    // R9: the PC stays word aligned
    assert_word_aligned_R9: assert property (@(negedge clk) disable iff (rst)
        (pc_o[1:0] == 2'b00));

endmodule

bind fetch_unit fetch_unit_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .br_sel   (br_sel),
    .alu_zero (alu_zero),
    .jmp_sel  (jmp_sel),
    .imm16    (imm16),
    .jtarget  (jtarget),
    .pc_o     (pc_o)
);

// File: tb/fetch_unit_tb_top.sv
module fetch_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int WORDS      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          br_sel = 1'b0;
    logic          alu_zero = 1'b0;
    logic          jmp_sel = 1'b0;
    logic [15:0]   imm16 = '0;
    logic [25:0]   jtarget = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc_o;
    logic [31:0]   instr_o;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] ins;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] model_pc = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_unit #(.IMEM_AW(AW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .br_sel   (br_sel),
        .alu_zero (alu_zero),
        .jmp_sel  (jmp_sel),
        .imm16    (imm16),
        .jtarget  (jtarget),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .pc_o     (pc_o),
        .instr_o  (instr_o)
    );

    function automatic logic [31:0] word_at(int idx);
        return 32'h5A00_0000 + 32'(idx) * 32'h0001_0101;
    endfunction

    function automatic logic [31:0] word_for_pc(logic [31:0] pc);
        return word_at(int'(pc[AW+1:2]));
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // Driver: drives one cycle of controls, pushes the expected next state.
    task automatic step(input logic r, input logic b, input logic z,
                        input logic j, input logic [15:0] im,
                        input logic [25:0] tg, input string tag);
        logic [31:0] nxt;
        @(posedge clk); #1;
        // R9: rising edge must not have moved the PC
        check(pc_o == model_pc, "R9", pc_o, model_pc);
        rst = r; br_sel = b; alu_zero = z; jmp_sel = j; imm16 = im; jtarget = tg;
        if (r)          nxt = 32'h0;
        else if (j)     nxt = {model_pc[31:28], tg, 2'b00};
        else if (b && z) nxt = model_pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
        else            nxt = model_pc + 32'd4;
        sb_q.push_back('{pc: nxt, ins: word_for_pc(nxt), tag: tag});
        model_pc = nxt;
    endtask

    // Monitor: compares at the rising edge, half a period after the update.
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(pc_o == e.pc, e.tag, pc_o, e.pc);
                check(instr_o == e.ins, {e.tag, "/R8"}, instr_o, e.ins);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // R10: fill the store while reset holds the PC
        for (int i = 0; i < WORDS; i++) begin
            @(posedge clk); #1;
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = word_at(i);
        end
        @(posedge clk); #1;
        ld_en = 1'b0;
        @(posedge clk); #1;
        // R1: reset state, R10: word 0 visible
        check(pc_o == 32'h0, "R1", pc_o, 32'h0);
        check(instr_o == word_at(0), "R10", instr_o, word_at(0));

        step(1, 0, 0, 0, 16'h0, 26'h0, "R1");        // reset held: 0
        step(0, 0, 0, 0, 16'h0, 26'h0, "R2");        // 4
        step(0, 0, 0, 0, 16'h7, 26'h9, "R2");        // 8
        step(0, 0, 0, 0, 16'h0, 26'h0, "R2");        // C
        step(0, 1, 0, 0, 16'h5, 26'h0, "R5");        // 10
        step(0, 0, 1, 0, 16'h5, 26'h0, "R6");        // 14
        step(0, 1, 1, 0, 16'h5, 26'h0, "R3");        // 2C
        step(0, 1, 1, 0, 16'hFFF8, 26'h0, "R4");     // 10
        step(0, 0, 0, 1, 16'h0, 26'h30, "R7");       // C0
        step(0, 1, 1, 1, 16'h4, 26'h3, "R7");        // C, jump wins
        step(0, 1, 1, 0, 16'hFFF0, 26'h0, "R4");     // FFFFFFD0
        step(0, 0, 0, 1, 16'h0, 26'h5, "R7");        // F0000014
        step(0, 0, 0, 0, 16'h0, 26'h0, "R2");        // F0000018
        step(0, 1, 1, 0, 16'h0, 26'h0, "R3");        // F000001C, zero offset
        step(1, 1, 1, 1, 16'h1, 26'h1, "R1");        // mid-run reset: 0
        step(1, 0, 0, 0, 16'h0, 26'h0, "R1");        // still 0
        step(0, 0, 0, 0, 16'h0, 26'h0, "R2");        // 4
        repeat (2) @(posedge clk);
        #1;
        report();
        $finish;
    end

endmodule